// File: doc/BRIEF.md
# SPI Multichannel ADC Scan Controller

This block is an SPI master that walks a programmed list of input channels on an external 12-bit serial converter. One converter is chosen from up to three that share the clock and both data lines. Each converter has its own active-low chip select. Every conversion frame is exactly sixteen serial clocks long, and the chip select is released between frames.

The converter returns the result for a channel one frame after that channel was requested. The controller therefore pipelines the scan. While it sends the command for the next list entry, it receives the sample for the previous one. It tags each sample with a one-frame-delayed channel number. At the end of the scan it adds one dummy frame to collect the last sample. Whatever arrives in the first frame of a scan belongs to the converter's earlier or power-up channel, so it is discarded.

On the user side, a one-cycle start pulse launches a scan. The start pulse captures the device number, the channel count, the channel list and the clock divider setting. Results come out as a (device, channel, 12-bit value) triple with a one-cycle valid strobe. A busy flag covers the whole scan.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Every chip-select window contains exactly 16 SCLK periods, never more.
- R2: Between two frames of a scan, all chip selects stay high for at least one full SCLK period.
- R3: SCLK idles high when no chip select is asserted. MOSI changes only on SCLK falling edges, and MISO is sampled on rising edges. A chip select changes level only while SCLK is high.
- R4: The command word is sent MSB first, with the channel number in bits 13:11 and every other bit 0.
- R5: A scan of K channels issues exactly K+1 frames. The last of these is a flush frame that commands channel 0.
- R6: res_valid pulses exactly K times per scan. Result i carries channel chan_list[3*i +: 3], in ascending i, together with that channel's conversion. The data of the first frame of a scan is discarded.
- R7: res_data holds the last 12 bits received in the frame, MSB first. The first 4 received bits have no effect on it.
- R8: Only the chip select of the captured device (cs_n[dev_sel], 0 to 2) is ever asserted, and res_dev reports that device. A start with dev_sel of 3, or with a chan_count of 0 or above 8, is ignored.
- R9: The SCLK period is 2*max(half_div,1) cycles of clk.
- R10: busy rises in the cycle after an accepted start and falls together with the last res_valid. Start pulses while busy have no effect.
- R11: After reset, cs_n is all ones, sclk is 1, mosi is 0, and busy and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan launch pulse |
| dev_sel | input | 2 | Converter to scan, 0 to 2 |
| chan_count | input | 4 | Number of list entries to scan, 1 to 8 |
| chan_list | input | 24 | Channel list, entry i in bits 3*i+2:3*i |
| half_div | input | 8 | SCLK half period in clk cycles (0 acts as 1) |
| miso | input | 1 | Serial data from the converters |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial command data |
| cs_n | output | 3 | Active-low chip selects, one per converter |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | Result strobe |
| res_dev | output | 2 | Device of the result |
| res_chan | output | 3 | Channel of the result |
| res_data | output | 12 | 12-bit conversion value |

## Verification
The bench builds the block with its default parameters: three devices, an eight-entry list and an 8-bit divider. These values reach the full list length and the highest device number, and the bench fills an entire scan with a reversed list. The bench runs half_div at 0, 1 and 3. This covers the fastest divide-by-two clock, the zero-clamp case and a slower rate, so both the period and the inter-frame gap are measured against the divider. A converter model keeps a per-device selected channel and puts a nonzero pattern in the four leading bits. This exposes any misalignment of the one-frame delay or of the 12-bit window.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_BITS = 16;
  localparam int RES_W      = 12;
  localparam int CH_W       = 3;
  localparam int CMD_CH_LSB = 11;

  typedef enum logic [1:0] {FR_IDLE, FR_SHIFT, FR_TAIL} frame_st_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT} seq_st_t;

  function automatic logic [FRAME_BITS-1:0] mk_cmd(input logic [CH_W-1:0] ch);
    logic [FRAME_BITS-1:0] w;
    w = '0;
    w[CMD_CH_LSB +: CH_W] = ch;
    return w;
  endfunction
endpackage

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim = (half_div == '0) ? DIV_W'(1) : half_div;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_scan_frame.sv
module adc_scan_frame
  import adc_scan_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int NBITS   = FRAME_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [NBITS-1:0]   cmd,
  input  logic [NUM_DEV-1:0] dev_oh,
  input  logic               tick,
  input  logic               miso,
  output logic               active,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_DEV-1:0] cs_n,
  output logic               done,
  output logic [NBITS-1:0]   rx
);
  localparam int NB_W = $clog2(NBITS) + 1;

  frame_st_t        st;
  logic [NBITS-1:0] sh;
  logic [NB_W-1:0]  nbit;
  logic [1:0]       gcnt;

  assign active = (st != FR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= FR_IDLE;
      sclk <= 1'b1;
      mosi <= 1'b0;
      cs_n <= '1;
      done <= 1'b0;
      sh   <= '0;
      rx   <= '0;
      nbit <= '0;
      gcnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        FR_IDLE: if (go) begin
          sh   <= cmd;
          cs_n <= ~dev_oh;
          nbit <= '0;
          gcnt <= '0;
          st   <= FR_SHIFT;
        end
        FR_SHIFT: if (tick) begin
          if (sclk) begin
            // leading (falling) edge: present next command bit
            sclk <= 1'b0;
            mosi <= sh[NBITS-1];
            sh   <= {sh[NBITS-2:0], 1'b0};
          end else begin
            // trailing (rising) edge: capture returned bit
            sclk <= 1'b1;
            rx   <= {rx[NBITS-2:0], miso};
            nbit <= nbit + NB_W'(1);
            if (nbit == NB_W'(NBITS - 1)) st <= FR_TAIL;
          end
        end
        FR_TAIL: if (tick) begin
          gcnt <= gcnt + 2'd1;
          if (gcnt == 2'd0) begin
            cs_n <= '1;
            mosi <= 1'b0;
          end
          if (gcnt == 2'd2) begin
            done <= 1'b1;
            st   <= FR_IDLE;
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int MAX_CH  = 8,
  parameter int DIV_W   = 8,
  localparam int DEV_W  = $clog2(NUM_DEV),
  localparam int CNT_W  = $clog2(MAX_CH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [DEV_W-1:0]       dev_sel,
  input  logic [CNT_W-1:0]       chan_count,
  input  logic [MAX_CH*CH_W-1:0] chan_list,
  input  logic [DIV_W-1:0]       half_div,
  input  logic                   miso,
  output logic                   sclk,
  output logic                   mosi,
  output logic [NUM_DEV-1:0]     cs_n,
  output logic                   busy,
  output logic                   res_valid,
  output logic [DEV_W-1:0]       res_dev,
  output logic [CH_W-1:0]        res_chan,
  output logic [RES_W-1:0]       res_data
);
  seq_st_t                sq;
  logic [DEV_W-1:0]       dev_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [MAX_CH*CH_W-1:0] list_q;
  logic [DIV_W-1:0]       half_q;
  logic [CNT_W-1:0]       fidx;
  logic [CH_W-1:0]        prev_ch;
  logic [CH_W-1:0]        cur_ch;
  logic                   go;
  logic [FRAME_BITS-1:0]  cmd_q;
  logic [NUM_DEV-1:0]     dev_oh;
  logic                   f_active, f_tick, f_done;
  logic [FRAME_BITS-1:0]  f_rx;
  logic                   start_ok;

  assign start_ok = start && !busy && (chan_count != '0) &&
                    (chan_count <= CNT_W'(MAX_CH)) && (dev_sel < DEV_W'(NUM_DEV));

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign dev_oh[g] = (dev_q == DEV_W'(g));
  end

  // channel for the frame being launched; the flush frame commands 0
  always_comb begin
    cur_ch = '0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (fidx == CNT_W'(i) && CNT_W'(i) < cnt_q) cur_ch = list_q[i*CH_W +: CH_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq        <= SQ_IDLE;
      busy      <= 1'b0;
      go        <= 1'b0;
      res_valid <= 1'b0;
      res_dev   <= '0;
      res_chan  <= '0;
      res_data  <= '0;
      dev_q     <= '0;
      cnt_q     <= '0;
      list_q    <= '0;
      half_q    <= '0;
      fidx      <= '0;
      prev_ch   <= '0;
      cmd_q     <= '0;
    end else begin
      go        <= 1'b0;
      res_valid <= 1'b0;
      case (sq)
        SQ_IDLE: if (start_ok) begin
          busy   <= 1'b1;
          dev_q  <= dev_sel;
          cnt_q  <= chan_count;
          list_q <= chan_list;
          half_q <= half_div;
          fidx   <= '0;
          sq     <= SQ_LAUNCH;
        end
        SQ_LAUNCH: begin
          go    <= 1'b1;
          cmd_q <= mk_cmd(cur_ch);
          sq    <= SQ_WAIT;
        end
        SQ_WAIT: if (f_done) begin
          prev_ch <= cur_ch;
          if (fidx != '0) begin
            res_valid <= 1'b1;
            res_dev   <= dev_q;
            res_chan  <= prev_ch;
            res_data  <= f_rx[RES_W-1:0];
          end
          if (fidx == cnt_q) begin
            busy <= 1'b0;
            sq   <= SQ_IDLE;
          end else begin
            fidx <= fidx + CNT_W'(1);
            sq   <= SQ_LAUNCH;
          end
        end
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  adc_scan_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(f_active), .half_div(half_q), .tick(f_tick)
  );

  adc_scan_frame #(.NUM_DEV(NUM_DEV), .NBITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst(rst), .go(go), .cmd(cmd_q), .dev_oh(dev_oh),
    .tick(f_tick), .miso(miso), .active(f_active), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .done(f_done), .rx(f_rx)
  );
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int NUM_DEV = 3,
  parameter int DEV_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               sclk,
  input logic [NUM_DEV-1:0] cs_n,
  input logic               busy,
  input logic               res_valid,
  input logic [DEV_W-1:0]   res_dev
);
  logic       sclk_d;
  logic [5:0] nfall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      nfall  <= '0;
    end else begin
      sclk_d <= sclk;
      if (&cs_n) nfall <= '0;
      else if (sclk_d && !sclk) nfall <= nfall + 6'd1;
    end
  end

  assert_max_clocks_R1: assert property (@(posedge clk) disable iff (rst)
    nfall <= 6'd16);
  assert_full_frame_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(&cs_n) |-> nfall == 6'd16);
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> sclk);
  assert_cs_edge_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cs_n) |-> (sclk && $past(sclk)));
  assert_one_cs_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);
  assert_dev_range_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_dev < DEV_W'(NUM_DEV)));
  assert_valid_in_scan_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(busy));
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> res_valid);
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .busy(busy),
  .res_valid(res_valid), .res_dev(res_dev)
);

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  dev_sel = '0;
  logic [3:0]  chan_count = '0;
  logic [23:0] chan_list = '0;
  logic [7:0]  half_div = 8'd1;
  logic        miso = 1'b0;
  logic        sclk, mosi, busy, res_valid;
  logic [2:0]  cs_n;
  logic [1:0]  res_dev;
  logic [2:0]  res_chan;
  logic [11:0] res_data;

  always #4 clk = ~clk;

  adc_scan_ctrl u_adc_scan_ctrl (
    .clk(clk), .rst(rst), .start(start), .dev_sel(dev_sel), .chan_count(chan_count),
    .chan_list(chan_list), .half_div(half_div), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .busy(busy), .res_valid(res_valid), .res_dev(res_dev),
    .res_chan(res_chan), .res_data(res_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [11:0] conv(input int d, input int c);
    return 12'(d * 'h300 + c * 'h111 + 5);
  endfunction

  // converter model
  logic        m_act = 1'b0;
  int          m_dev, m_rise, m_fall;
  logic [15:0] m_cmd, m_word, last_cmd;
  logic [2:0]  m_sel [3] = '{3'd0, 3'd0, 3'd0};
  int frames, bad_clk, bad_cmd, idle_err;
  int dev_frames [3];

  always @(cs_n) begin
    if (!m_act && cs_n != 3'b111 && !$isunknown(cs_n)) begin
      m_act  = 1'b1;
      m_dev  = !cs_n[0] ? 0 : (!cs_n[1] ? 1 : 2);
      m_rise = 0;
      m_fall = 0;
      m_cmd  = '0;
      m_word = {4'hA, conv(m_dev, int'(m_sel[m_dev]))};
      frames++;
      dev_frames[m_dev]++;
    end else if (m_act && cs_n == 3'b111) begin
      m_act = 1'b0;
      if (m_rise != 16) bad_clk++;
      if ((m_cmd & 16'hC7FF) != 0) bad_cmd++;
      last_cmd = m_cmd;
      m_sel[m_dev] = m_cmd[13:11];
    end
  end

  always @(negedge sclk) begin
    if (!m_act) idle_err++;
    else begin
      if (m_fall < 16) miso = m_word[15 - m_fall];
      m_fall++;
    end
  end

  always @(posedge sclk) begin
    if (m_act) begin
      m_cmd = {m_cmd[14:0], mosi};
      m_rise++;
    end
  end

  // result, period and gap monitors
  int nres;
  int r_ch [16];
  int r_dat [16];
  int r_dev [16];
  int cyc = 0, last_fall = -1, pmin, pmax, hi_run, gmin;
  bit seen_frame;
  logic sclk_p = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (res_valid && nres < 16) begin
      r_ch[nres]  = int'(res_chan);
      r_dat[nres] = int'(res_data);
      r_dev[nres] = int'(res_dev);
      nres++;
    end
    if (cs_n == 3'b111) begin
      last_fall = -1;
      hi_run++;
    end else begin
      if (seen_frame && hi_run > 0 && hi_run < gmin) gmin = hi_run;
      hi_run = 0;
      seen_frame = 1'b1;
      if (sclk_p && !sclk) begin
        if (last_fall >= 0) begin
          if (cyc - last_fall < pmin) pmin = cyc - last_fall;
          if (cyc - last_fall > pmax) pmax = cyc - last_fall;
        end
        last_fall = cyc;
      end
    end
    sclk_p = sclk;
  end

  task automatic clear_stats();
    nres = 0; frames = 0; bad_clk = 0; bad_cmd = 0; idle_err = 0;
    dev_frames[0] = 0; dev_frames[1] = 0; dev_frames[2] = 0;
    pmin = 1 << 20; pmax = 0; gmin = 1 << 20; hi_run = 0; seen_frame = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_scan(input int dev, input int k, input logic [23:0] list,
                          input int half, input int intr_at, input string tag);
    int eff;
    eff = (half == 0) ? 1 : half;
    clear_stats();
    @(negedge clk);
    dev_sel = 2'(dev); chan_count = 4'(k); chan_list = list; half_div = 8'(half); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R10 busy after start"}, int'(busy), 1);
    if (intr_at > 0) begin
      repeat (intr_at) @(negedge clk);
      dev_sel = 2'd2; chan_count = 4'd2; chan_list = 24'o77; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {tag, " R10 busy kept"}, int'(busy), 1);
    end
    wait_idle();
    chk(busy == 1'b0, {tag, " R10 busy cleared"}, int'(busy), 0);
    chk(nres == k, {tag, " R6 result count"}, nres, k);
    for (int i = 0; i < k && i < nres; i++) begin
      chk(r_ch[i] == int'(list[3*i +: 3]), {tag, " R6 channel tag"}, r_ch[i], int'(list[3*i +: 3]));
      chk(r_dat[i] == int'(conv(dev, int'(list[3*i +: 3]))), {tag, " R7 result data"},
          r_dat[i], int'(conv(dev, int'(list[3*i +: 3]))));
      chk(r_dev[i] == dev, {tag, " R8 device tag"}, r_dev[i], dev);
    end
    chk(frames == k + 1, {tag, " R5 frame count"}, frames, k + 1);
    chk(last_cmd == 16'h0000, {tag, " R5 flush command"}, int'(last_cmd), 0);
    chk(bad_clk == 0, {tag, " R1 frames without 16 clocks"}, bad_clk, 0);
    chk(bad_cmd == 0, {tag, " R4 command stray bits"}, bad_cmd, 0);
    chk(idle_err == 0, {tag, " R3 clock outside chip select"}, idle_err, 0);
    chk(dev_frames[dev] == k + 1, {tag, " R8 selected device frames"}, dev_frames[dev], k + 1);
    chk(pmin == 2 * eff && pmax == 2 * eff, {tag, " R9 SCLK period"}, pmax, 2 * eff);
    chk(gmin >= 2 * eff, {tag, " R2 inter-frame gap"}, gmin, 2 * eff);
  endtask

  task automatic test_reset();
    chk(cs_n == 3'b111, "R11 cs_n at reset", int'(cs_n), 7);
    chk(sclk == 1'b1, "R11 sclk at reset", int'(sclk), 1);
    chk(mosi == 1'b0, "R11 mosi at reset", int'(mosi), 0);
    chk(busy == 1'b0, "R11 busy at reset", int'(busy), 0);
    chk(res_valid == 1'b0, "R11 res_valid at reset", int'(res_valid), 0);
  endtask

  task automatic test_bad_start(input int dev, input int k, input string tag);
    clear_stats();
    @(negedge clk);
    dev_sel = 2'(dev); chan_count = 4'(k); chan_list = 24'o1234; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, {tag, " R8 ignored start busy"}, int'(busy), 0);
    chk(frames == 0, {tag, " R8 ignored start frames"}, frames, 0);
    chk(nres == 0, {tag, " R8 ignored start results"}, nres, 0);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_scan(0, 4, {12'd0, 3'd7, 3'd6, 3'd5, 3'd0}, 1, 0, "scan dev0 fast");
    run_scan(1, 1, 24'o3, 3, 0, "single channel dev1");
    run_scan(2, 8, 24'o01234567, 0, 0, "full list dev2 div0");
    run_scan(0, 3, 24'o246, 2, 20, "start while busy");
    test_bad_start(3, 2, "device 3");
    test_bad_start(1, 0, "count 0");
    test_bad_start(1, 9, "count 9");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule